// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Refresh

This block is a watchdog built around a 16-bit up-counter. A two-stage prescaler drives the counter: it divides the clock by a base ratio and then by two, and an optional extra divide-by-sixteen can follow. When the count reaches the fixed expiry value 7CFFh, the block raises a status flag. Once that flag has been held for two consecutive cycles, the block asks the chip's reset logic for a reset.

There are two ways to start the watchdog. One is a hardware strap that is sampled once the internal reset is released. The other is a software write to the start/refresh flag. Once the watchdog is started, only a reset stops it. A refresh takes two writes. Software first writes the refresh-arm flag, then writes the start/refresh flag within twelve cycles. A refresh loads the counter high byte from the reload register, clears the low byte and clears the prescalers. A start/refresh write that does not follow an arm within that window does not move a running counter.

A single 8-bit reload register holds the settings. Bit 7 selects the slow prescaler and bits 6:0 give the high-byte reload value. The register can be written and read back at any time. The status flag is also the value that software reads at the start/refresh bit position.

Top module: `wdog_two_step`

## Requirements
- R1: The counter advances once every 2*BASE_DIV clocks while running (24 with defaults); with reload bit 7 set it advances once every 32*BASE_DIV clocks.
- R2: A refresh loads the counter with {0, reload[6:0], 00h} and clears the prescalers; with reload 7Ch and fast rate the status rises 255 ticks (510*BASE_DIV clocks) after the refresh edge.
- R3: The reload register takes `reload_wdata` on `reload_wr` and is always visible on `reload_rdata`.
- R4: Asserting `rst_n` clears the reload register, `status` and `reset_req`, zeroes the counter and stops the watchdog.
- R5: With `hw_start` high through reset, the watchdog runs from a count of zero starting at the first clock after the internal reset is released.
- R6: A start/refresh write while the watchdog is stopped starts it from its current count of zero; once started it keeps running until reset.
- R7: A start/refresh write refreshes only if it is sampled 1 to 12 clock edges after the edge that sampled a refresh-arm write; at 13 edges or later it has no effect on a running counter.
- R8: A start/refresh write with no pending arm, or an arm write with no following start/refresh write, leaves a running counter unchanged.
- R9: `status` is high exactly while the counter holds 7CFFh and falls when the counter next advances.
- R10: `reset_req` is high from the second consecutive cycle that `status` is high, and only while `status` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_start | input | 1 | Hardware start strap, level sensitive |
| refresh_arm_wr | input | 1 | One-cycle write pulse setting the refresh-arm flag |
| start_refresh_wr | input | 1 | One-cycle write pulse setting the start/refresh flag |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_wdata | input | 8 | Reload register write data (bit 7 slow select, 6:0 high-byte value) |
| reload_rdata | output | 8 | Reload register readback |
| status | output | 1 | Expiry status, also the readback at the start/refresh bit position |
| reset_req | output | 1 | Reset request to the chip reset logic |

## Verification
The bench builds the block with BASE_DIV set to 1, so one tick takes two clocks. The window, slow divider and expiry value keep their defaults. With this setting, a full run from a count of zero to 7CFFh takes about 64 thousand cycles, which lets both start paths be timed to the exact cycle. A refresh from 7Ch reaches expiry in 510 cycles at the fast rate and 8160 at the slow rate. This keeps the arm-window boundary, the ignored writes and the status and request timing cheap enough to measure precisely.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int WD_CNT_W = 16;
  parameter int WD_REL_W = 8;
  typedef logic [WD_CNT_W-1:0] wd_count_t;
  typedef logic [WD_REL_W-1:0] wd_reload_t;
  localparam wd_count_t WD_EXPIRE_DEF = 16'h7CFF;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int BASE_DIV = 12,
  parameter int SLOW_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic slow,
  output logic tick
);
  localparam int AW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [AW-1:0] div_a_q, div_a_d;
  logic          half_q, half_d;
  logic [CW-1:0] div_c_q, div_c_d;
  logic          a_wrap, c_wrap, mid_tick;

  assign a_wrap   = (div_a_q == AW'(BASE_DIV - 1));
  assign c_wrap   = (div_c_q == CW'(SLOW_DIV - 1));
  assign mid_tick = en & a_wrap & half_q;
  assign tick     = mid_tick & (~slow | c_wrap);

  always_comb begin
    div_a_d = div_a_q;
    half_d  = half_q;
    div_c_d = div_c_q;
    if (clr) begin
      div_a_d = '0;
      half_d  = 1'b0;
      div_c_d = '0;
    end else if (en) begin
      div_a_d = a_wrap ? '0 : div_a_q + 1'b1;
      if (a_wrap) half_d = ~half_q;
      if (mid_tick) div_c_d = c_wrap ? '0 : div_c_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_a_q <= '0;
      half_q  <= 1'b0;
      div_c_q <= '0;
    end else begin
      div_a_q <= div_a_d;
      half_q  <= half_d;
      div_c_q <= div_c_d;
    end
  end
endmodule

// File: rtl/wdog_arm_window.sv
module wdog_arm_window #(
  parameter int WINDOW = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic start_wr,
  output logic armed,
  output logic refresh
);
  localparam int WW = $clog2(WINDOW + 1);

  logic [WW-1:0] left_q, left_d;

  assign armed   = (left_q != '0);
  assign refresh = start_wr & armed;

  always_comb begin
    left_d = left_q;
    if (arm_wr)       left_d = WW'(WINDOW);
    else if (refresh) left_d = '0;
    else if (armed)   left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter wd_count_t EXPIRE = WD_EXPIRE_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic [WD_REL_W-2:0] load_hi,
  output wd_count_t           count,
  output logic                at_expire
);
  localparam int LO_W  = WD_CNT_W - WD_REL_W;
  localparam int PAD_W = WD_CNT_W - LO_W - (WD_REL_W - 1);

  wd_count_t cnt_q, cnt_d;

  assign count     = cnt_q;
  assign at_expire = (cnt_q == EXPIRE);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = {{PAD_W{1'b0}}, load_hi, {LO_W{1'b0}}};
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_two_step.sv
module wdog_two_step
  import wdog_pkg::*;
#(
  parameter int        BASE_DIV = 12,
  parameter int        SLOW_DIV = 16,
  parameter int        WINDOW   = 12,
  parameter wd_count_t EXPIRE   = WD_EXPIRE_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_start,
  input  logic       refresh_arm_wr,
  input  logic       start_refresh_wr,
  input  logic       reload_wr,
  input  logic [7:0] reload_wdata,
  output logic [7:0] reload_rdata,
  output logic       status,
  output logic       reset_req
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       running_q, running_d;
  wd_reload_t reload_q, reload_d;
  logic       hold_q;
  logic       tick, refresh, armed, at_expire;
  wd_count_t  count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    running_d = running_q | hw_start | start_refresh_wr;
    reload_d  = reload_wr ? reload_wdata : reload_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      running_q <= 1'b0;
      reload_q  <= '0;
      hold_q    <= 1'b0;
    end else begin
      running_q <= running_d;
      reload_q  <= reload_d;
      hold_q    <= status;
    end
  end

  wdog_arm_window #(.WINDOW(WINDOW)) u_window (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .arm_wr   (refresh_arm_wr),
    .start_wr (start_refresh_wr),
    .armed    (armed),
    .refresh  (refresh)
  );

  wdog_prescaler #(.BASE_DIV(BASE_DIV), .SLOW_DIV(SLOW_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (running_q),
    .clr   (refresh),
    .slow  (reload_q[WD_REL_W-1]),
    .tick  (tick)
  );

  wdog_counter #(.EXPIRE(EXPIRE)) u_count (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .load      (refresh),
    .load_hi   (reload_q[WD_REL_W-2:0]),
    .count     (count),
    .at_expire (at_expire)
  );

  assign reload_rdata = reload_q;
  assign status       = running_q & at_expire;
  assign reset_req    = status & hold_q;
endmodule

// File: rtl/wdog_two_step_chk.sv
module wdog_two_step_chk
  import wdog_pkg::*;
(
  input logic      clk,
  input logic      rst_int_n,
  input logic      running,
  input logic      tick,
  input logic      refresh,
  input wd_count_t count,
  input logic      status,
  input logic      reset_req
);
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    running |=> running);

  a_r2_refresh_clears_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    refresh |=> (count[7:0] == 8'h00 && !count[WD_CNT_W-1]));

  a_r8_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_int_n)
    !refresh |=> (count == $past(count) || count == wd_count_t'($past(count) + 1'b1)));

  a_r9_status_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status && !tick && !refresh) |=> status);

  a_r9_status_drops: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status && tick) |=> !status);

  a_r10_req_after_two: assert property (@(posedge clk) disable iff (!rst_int_n)
    reset_req |-> (status && $past(status)));

  a_r4_stopped_is_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !running |-> (count == '0));
endmodule

bind wdog_two_step wdog_two_step_chk u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .running   (running_q),
  .tick      (tick),
  .refresh   (refresh),
  .count     (count),
  .status    (status),
  .reset_req (reset_req)
);

// File: tb/wdog_two_step_test.sv
module wdog_two_step_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_start = 1'b0;
  logic       refresh_arm_wr = 1'b0;
  logic       start_refresh_wr = 1'b0;
  logic       reload_wr = 1'b0;
  logic [7:0] reload_wdata = 8'h00;
  logic [7:0] reload_rdata;
  logic       status;
  logic       reset_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wdog_two_step #(.BASE_DIV(1)) uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .hw_start         (hw_start),
    .refresh_arm_wr   (refresh_arm_wr),
    .start_refresh_wr (start_refresh_wr),
    .reload_wr        (reload_wr),
    .reload_wdata     (reload_wdata),
    .reload_rdata     (reload_rdata),
    .status           (status),
    .reset_req        (reset_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic pulse_arm();   refresh_arm_wr = 1'b1;   step(); refresh_arm_wr = 1'b0;   endtask
  task automatic pulse_start(); start_refresh_wr = 1'b1; step(); start_refresh_wr = 1'b0; endtask

  task automatic write_reload(input logic [7:0] v);
    reload_wdata = v; reload_wr = 1'b1; step(); reload_wr = 1'b0;
  endtask

  task automatic wait_status(input int limit, output int n);
    n = 0;
    while (n < limit && status !== 1'b1) begin step(); n++; end
  endtask

  task automatic refresh_now(); pulse_arm(); pulse_start(); endtask

  task automatic t_reset_state();
    hw_start = 1'b0;
    do_reset();
    idle(4);
    check("R4 status after reset", int'(status), 0);
    check("R4 reset_req after reset", int'(reset_req), 0);
    check("R4 reload after reset", int'(reload_rdata), 0);
  endtask

  task automatic t_reload_rw();
    write_reload(8'hA5);
    check("R3 reload readback A5", int'(reload_rdata), 8'hA5);
    write_reload(8'h7C);
    check("R3 reload readback 7C", int'(reload_rdata), 8'h7C);
  endtask

  task automatic t_sw_start();
    int n;
    idle(2000);
    check("R4 stopped no status", int'(status), 0);
    pulse_start();
    wait_status(70000, n);
    check("R6 sw start from zero, cycles to expiry", n, 63998);
  endtask

  task automatic t_fast_refresh();
    int n;
    pulse_arm();
    idle(11);
    pulse_start();
    wait_status(1000, n);
    check("R7 start at 12th edge refreshes, R2 cycles", n, 510);
    check("R10 no request first status cycle", int'(reset_req), 0);
    step();
    check("R9 status second cycle", int'(status), 1);
    check("R10 request second cycle", int'(reset_req), 1);
    step();
    check("R9 status falls on next count", int'(status), 0);
    check("R10 request falls with status", int'(reset_req), 0);
  endtask

  task automatic t_window_late();
    int n;
    refresh_now();
    idle(49);
    pulse_arm();
    idle(12);
    pulse_start();
    wait_status(1000, n);
    check("R7 start at 13th edge ignored", n, 510 - 63);
  endtask

  task automatic t_no_arm();
    int n;
    refresh_now();
    idle(99);
    pulse_start();
    idle(49);
    pulse_arm();
    wait_status(1000, n);
    check("R8 lone writes ignored", n, 510 - 150);
  endtask

  task automatic t_slow();
    int n;
    write_reload(8'hFC);
    refresh_now();
    wait_status(10000, n);
    check("R1 slow prescaler cycles to expiry", n, 8160);
    check("R10 slow no request first cycle", int'(reset_req), 0);
    step();
    check("R10 slow request second cycle", int'(reset_req), 1);
  endtask

  task automatic t_reset_mid();
    do_reset();
    idle(2);
    check("R4 reload cleared by reset", int'(reload_rdata), 0);
    check("R4 status cleared by reset", int'(status), 0);
  endtask

  task automatic t_strap();
    int n;
    hw_start = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    wait_status(70000, n);
    check("R5 strap start, cycles from release", n, 64001);
    hw_start = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_reload_rw();
    t_sw_start();
    t_fast_refresh();
    t_window_late();
    t_no_arm();
    t_slow();
    t_reset_mid();
    t_strap();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule